// File: doc/BRIEF.md
# Ordered Dial Sequence Lock

This block is a clocked state machine that unlocks only after it receives a fixed ordered series of dial operations. Each operation is a direction (clockwise or counter-clockwise) paired with a dial number. It arrives on a bus that is qualified by a valid strobe lasting one cycle. The machine counts how far the caller has progressed through the series. It raises its open output once the last operation has been accepted.

The programmed series is turn right to 13, then left to 22, then right to 3. The order is significant. Entering the same numbers in a different order, or with the wrong direction, does not unlock the block. An operation that breaks the series throws away the progress made so far. The exception is an operation that itself begins the series, which counts as step one.

Once open, the lock stays open until a relock request or a synchronous reset arrives. A small progress value is brought out so that a test environment can follow the machine.

Top module: `lock_seq_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `lock_state` = 0 and `lock_open` = 0. Reset takes priority over every other input.
- R2: `lock_state` encodes progress as follows: 0 means no step done, 1 means step one done, 2 means steps one and two done, and 3 means open. An operation is valid when `op_valid` is high, and `op_right` = 1 means right while 0 means left. A valid right-13 moves 0 to 1. A valid left-22 moves 1 to 2. A valid right-3 moves 2 to 3. Each of these moves happens on the edge that samples the operation.
- R3: `lock_open` is registered and is high in exactly the cycles where `lock_state` is 3.
- R4: A cycle with `op_valid` low and `relock` low leaves `lock_state` unchanged.
- R5: In states 0, 1 and 2, a valid operation that is not the expected next step sends the state to 0. If that operation is right-13, the state goes to 1 instead.
- R6: In state 3, valid operations have no effect, and the lock stays open until `relock` or `rst`.
- R7: `relock` high at an edge sends the state to 0 from any state. It takes priority over an operation presented in the same cycle.
- R8: Right-13, left-22 and right-3 presented in any order other than the programmed one leave `lock_open` low.
- R9: Direction is part of each step. The correct number with the wrong direction counts as a wrong operation under R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies the dial operation for one cycle |
| op_right | input | 1 | Direction: 1 = right, 0 = left |
| op_value | input | 6 | Dial number of the operation |
| relock | input | 1 | Return to the locked starting state |
| lock_open | output | 1 | High while the lock is open |
| lock_state | output | 2 | Progress through the series (0..3) |

## Verification
The assertions check four rules on every cycle: the agreement between `lock_open` and state 3, that the state holds through idle cycles, that the open state is sticky, and that relock and reset return the machine to 0. They also check that a change of progress is either a single-step advance or a fall back to 0 or 1. Only the bench scenarios can show which particular operations count as matches. Those scenarios cover the direction sensitivity, the restart on a fresh right-13 after a mismatch, and the rejection of reordered values. A behavioural model of the series is compared against the state and the open output after every clock.

// File: rtl/lock_pkg.sv
package lock_pkg;
    localparam int DIAL_W    = 6;
    localparam int NUM_STEPS = 3;
    localparam int STATE_W   = $clog2(NUM_STEPS + 1);

    typedef logic [STATE_W-1:0] state_t;

    typedef struct packed {
        state_t state;
        logic   open;
    } lock_regs_t;
endpackage

// File: rtl/lock_step_match.sv
module lock_step_match #(
    parameter int                           DIAL_W    = lock_pkg::DIAL_W,
    parameter int                           NUM_STEPS = lock_pkg::NUM_STEPS,
    parameter logic [NUM_STEPS-1:0]         SEQ_DIR   = 3'b101,
    parameter logic [NUM_STEPS*DIAL_W-1:0]  SEQ_VAL   = {6'd3, 6'd22, 6'd13}
) (
    input  logic                 op_right,
    input  logic [DIAL_W-1:0]    op_value,
    output logic [NUM_STEPS-1:0] step_hit
);
    // One comparator per programmed step; step i occupies slice i of SEQ_VAL.
    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
        assign step_hit[i] = (op_right == SEQ_DIR[i]) &&
                             (op_value == SEQ_VAL[i*DIAL_W +: DIAL_W]);
    end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state #(
    parameter int NUM_STEPS = lock_pkg::NUM_STEPS,
    parameter int STATE_W   = lock_pkg::STATE_W
) (
    input  logic [STATE_W-1:0]   state_q,
    input  logic                 op_valid,
    input  logic                 relock,
    input  logic [NUM_STEPS-1:0] step_hit,
    output logic [STATE_W-1:0]   state_d
);
    localparam logic [STATE_W-1:0] OPEN_CODE = STATE_W'(NUM_STEPS);

    logic expected_hit;

    always_comb begin
        expected_hit = 1'b0;
        for (int i = 0; i < NUM_STEPS; i++) begin
            if (state_q == STATE_W'(i)) begin
                expected_hit = step_hit[i];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (relock) begin
            state_d = '0;
        end else if (state_q == OPEN_CODE) begin
            state_d = state_q;
        end else if (op_valid) begin
            if (expected_hit) begin
                state_d = STATE_W'(state_q + 1'b1);
            end else if (step_hit[0]) begin
                state_d = STATE_W'(1);
            end else begin
                state_d = '0;
            end
        end
    end
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm #(
    parameter int                                        DIAL_W  = lock_pkg::DIAL_W,
    parameter logic [lock_pkg::NUM_STEPS-1:0]            SEQ_DIR = 3'b101,
    parameter logic [lock_pkg::NUM_STEPS*DIAL_W-1:0]     SEQ_VAL = {6'd3, 6'd22, 6'd13}
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         op_valid,
    input  logic                         op_right,
    input  logic [DIAL_W-1:0]            op_value,
    input  logic                         relock,
    output logic                         lock_open,
    output logic [lock_pkg::STATE_W-1:0] lock_state
);
    import lock_pkg::*;

    localparam state_t OPEN_CODE = STATE_W'(NUM_STEPS);

    logic [NUM_STEPS-1:0] step_hit;
    state_t               state_next;
    lock_regs_t           regs_d;
    lock_regs_t           regs_q;

    lock_step_match #(
        .DIAL_W    (DIAL_W),
        .NUM_STEPS (NUM_STEPS),
        .SEQ_DIR   (SEQ_DIR),
        .SEQ_VAL   (SEQ_VAL)
    ) u_match (
        .op_right (op_right),
        .op_value (op_value),
        .step_hit (step_hit)
    );

    lock_next_state #(
        .NUM_STEPS (NUM_STEPS),
        .STATE_W   (STATE_W)
    ) u_next (
        .state_q  (regs_q.state),
        .op_valid (op_valid),
        .relock   (relock),
        .step_hit (step_hit),
        .state_d  (state_next)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = state_next;
        regs_d.open  = (state_next == OPEN_CODE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign lock_open  = regs_q.open;
    assign lock_state = regs_q.state;
endmodule

// File: rtl/lock_seq_checker.sv
module lock_seq_checker #(
    parameter int STATE_W   = lock_pkg::STATE_W,
    parameter int NUM_STEPS = lock_pkg::NUM_STEPS
) (
    input logic               clk,
    input logic               rst,
    input logic               op_valid,
    input logic               relock,
    input logic               lock_open,
    input logic [STATE_W-1:0] lock_state
);
    localparam logic [STATE_W-1:0] OPEN_CODE = STATE_W'(NUM_STEPS);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (lock_state == '0) && !lock_open);

    p_step_or_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lock_state) && lock_state > STATE_W'(1))
            |-> lock_state == STATE_W'($past(lock_state) + 1'b1));

    p_open_matches_state_r3: assert property (@(posedge clk) disable iff (rst)
        lock_open == (lock_state == OPEN_CODE));

    p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !relock) |=> $stable(lock_state));

    p_open_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_state == OPEN_CODE && !relock) |=> lock_open);

    p_relock_idle_r7: assert property (@(posedge clk) disable iff (rst)
        relock |=> (lock_state == '0) && !lock_open);
endmodule

bind lock_seq_fsm lock_seq_checker #(
    .STATE_W   (lock_pkg::STATE_W),
    .NUM_STEPS (lock_pkg::NUM_STEPS)
) u_lock_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .relock     (relock),
    .lock_open  (lock_open),
    .lock_state (lock_state)
);

// File: tb/tb_lock_seq_fsm.sv
module tb_lock_seq_fsm;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic       op_right = 1'b0;
    logic [5:0] op_value = '0;
    logic       relock = 1'b0;
    logic       lock_open;
    logic [1:0] lock_state;

    int    checks   = 0;
    int    failures = 0;
    int    model    = 0;
    int    cycles   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // The combination the lock must accept, in order.
    int want_dir [3] = '{1, 0, 1};
    int want_val [3] = '{13, 22, 3};

    lock_seq_fsm dut (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .op_right   (op_right),
        .op_value   (op_value),
        .relock     (relock),
        .lock_open  (lock_open),
        .lock_state (lock_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: progress counter against the wanted list.
    always @(posedge clk) begin
        if (rst || relock) begin
            model <= 0;
        end else if (model < 3 && op_valid) begin
            if (int'(op_right) == want_dir[model] && int'(op_value) == want_val[model])
                model <= model + 1;
            else if (int'(op_right) == want_dir[0] && int'(op_value) == want_val[0])
                model <= 1;
            else
                model <= 0;
        end
    end

    task automatic compare(input string req);
        checks++;
        if (int'(lock_state) != model || lock_open != (model == 3)) begin
            failures++;
            $display("FAIL %s: state=%0d open=%0b expected state=%0d open=%0b",
                     req, lock_state, lock_open, model, (model == 3));
        end
    endtask

    task automatic expect_state(input int exp, input string req);
        checks++;
        if (int'(lock_state) != exp || lock_open != (exp == 3)) begin
            failures++;
            $display("FAIL %s: state=%0d open=%0b expected state=%0d open=%0b",
                     req, lock_state, lock_open, exp, (exp == 3));
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) compare(cur_req);
    end

    task automatic drive(input logic v, input logic r, input int val, input logic rl);
        @(negedge clk);
        op_valid = v;
        op_right = r;
        op_value = 6'(val);
        relock   = rl;
    endtask

    task automatic dial(input logic r, input int val);
        drive(1'b1, r, val, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0, 1'b0);
    endtask

    task automatic do_relock();
        drive(1'b0, 1'b0, 0, 1'b1);
    endtask

    task automatic open_it();
        dial(1'b1, 13); dial(1'b0, 22); dial(1'b1, 3); idle(1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                failures++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
                done = 1'b1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        @(negedge clk); rst = 1'b0;
        expect_state(0, "R1");

        // R2/R3: correct order opens
        cur_req = "R2"; open_it();
        expect_state(3, "R3");
        cur_req = "R3"; idle(2);

        // R6: operations while open are ignored
        cur_req = "R6";
        dial(1'b0, 5); dial(1'b1, 13); dial(1'b1, 3); idle(1);
        expect_state(3, "R6");

        // R7: relock returns to idle
        cur_req = "R7"; do_relock(); idle(1);
        expect_state(0, "R7");

        // R4: idle gaps between steps keep progress
        cur_req = "R4";
        dial(1'b1, 13); idle(4); dial(1'b0, 22); idle(3);
        expect_state(2, "R4");
        dial(1'b1, 3); idle(1);
        expect_state(3, "R4");
        do_relock(); idle(1);

        // R5: mismatch drops to 0, fresh right-13 restarts at 1
        cur_req = "R5";
        dial(1'b1, 13); dial(1'b0, 22); dial(1'b0, 3); idle(1);
        expect_state(0, "R5");
        dial(1'b1, 13); dial(1'b1, 13); idle(1);
        expect_state(1, "R5");
        dial(1'b0, 22); dial(1'b1, 13); idle(1);
        expect_state(1, "R5");
        dial(1'b0, 40); idle(1);
        expect_state(0, "R5");

        // R7: relock has priority over a matching operation
        cur_req = "R7";
        dial(1'b1, 13); dial(1'b0, 22);
        drive(1'b1, 1'b1, 3, 1'b1); idle(1);
        expect_state(0, "R7");

        // R8: reordered values never open
        cur_req = "R8";
        dial(1'b1, 3); dial(1'b0, 22); dial(1'b1, 13); idle(1);
        expect_state(1, "R8");
        do_relock();
        dial(1'b0, 22); dial(1'b1, 13); dial(1'b1, 3); idle(1);
        expect_state(0, "R8");
        dial(1'b1, 13); dial(1'b1, 3); dial(1'b0, 22); idle(1);
        expect_state(0, "R8");

        // R9: wrong direction counts as wrong
        cur_req = "R9";
        dial(1'b0, 13); idle(1);
        expect_state(0, "R9");
        dial(1'b1, 13); dial(1'b1, 22); idle(1);
        expect_state(0, "R9");
        dial(1'b1, 13); dial(1'b0, 22); dial(1'b0, 3); idle(1);
        expect_state(0, "R9");

        // R1: reset mid-sequence and while open
        cur_req = "R1";
        dial(1'b1, 13); dial(1'b0, 22);
        @(negedge clk); rst = 1'b1; op_valid = 1'b1; op_right = 1'b1; op_value = 6'd3;
        @(negedge clk); rst = 1'b0; op_valid = 1'b0;
        expect_state(0, "R1");
        open_it();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        expect_state(0, "R1");
        idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule